// File: doc/BRIEF.md
# APB4 Completer Register Bank

This block is the peripheral side of an APB4 link in front of a bank of eight 32-bit registers. A requester presents a transfer in two phases. In the setup cycle the select is high and the enable is low. In the access cycle that follows, the enable is also high. The block decodes the word index from the address and merges write data one byte lane at a time under the write strobes. It can stretch the access phase by zero to three wait cycles, chosen on a configuration input. It also checks each access and reports a refused transfer on the error output.

A transfer is refused when its address lies beyond the bank, when a read carries any strobe bit, or when a non-secure access targets one of the two secure-only registers. A refused transfer changes no register, and a refused read returns zero. Read data appears only in the cycle in which the transfer completes. The privileged and instruction attribute bits are accepted but have no effect on the result.

Top module: `apb_rf_top`

## Requirements
- R1: After an active-low reset, every register reads as zero, and `readyOut`, `errOut` and `rdataOut` are low while reset is held.
- R2: `readyOut` is high only in cycles where `selIn` and `enableIn` are both high. A transfer completes on the first rising clock edge where `selIn`, `enableIn` and `readyOut` are all high.
- R3: With `waitCfg` = N (0 to 3), `readyOut` rises in the (N+1)th consecutive access cycle of a transfer, so each transfer spends exactly N+1 cycles in its access phase.
- R4: A write that completes without error updates byte n (bits 8n+7:8n) of the register selected by `addrIn[4:2]` only when `strbIn[n]` is 1. All other bytes and registers keep their values.
- R5: In the completing cycle of an error-free read, `rdataOut` equals the register selected by `addrIn[4:2]`. In every other cycle `rdataOut` is zero.
- R6: An access with any of `addrIn[11:5]` nonzero completes with `errOut` high, changes no register, and returns zero read data.
- R7: A read that completes with any `strbIn` bit set has `errOut` high and returns zero.
- R8: Registers 6 and 7 are secure-only. An access to them with `protIn[1]` = 1 (non-secure) completes with `errOut` high, leaves the register unchanged, and reads zero. With `protIn[1]` = 0 they behave like the other registers.
- R9: `errOut` is low in every cycle other than a completing cycle.
- R10: `protIn[0]` (privileged), `protIn[2]` (instruction) and `addrIn[1:0]` have no effect on the result of a transfer.
- R11: A new setup cycle may follow the completing cycle directly, with no idle cycle in between, and both transfers take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selIn | input | 1 | Completer select |
| enableIn | input | 1 | High in the access phase |
| writeIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | 12 | Byte address; bits 4:2 pick the register |
| wdataIn | input | 32 | Write data |
| strbIn | input | 4 | Byte-lane write strobes |
| protIn | input | 3 | [0] privileged, [1] non-secure, [2] instruction |
| waitCfg | input | 2 | Wait cycles inserted per access phase |
| rdataOut | output | 32 | Read data, valid only in the completing read cycle |
| readyOut | output | 1 | Completes the access phase when high |
| errOut | output | 1 | Transfer refused, valid only in the completing cycle |

## Verification
The bench uses the default 12-bit address with the fixed 32-bit bank. The bit above the register index can therefore be set, which produces an out-of-range access that aliases onto register 0. This shows that a refused write leaves the aliased register untouched. Because `waitCfg` is a port, a single build steps through all four wait settings, from an access that is ready at once to the longest stretch of three wait cycles. Every read and every write is run under each of those settings.

// File: rtl/apb_rf_pkg.sv
package apb_rf_pkg;
  localparam int DATA_W    = 32;
  localparam int STRB_W    = DATA_W / 8;
  localparam int NUM_REGS  = 8;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int WAIT_W    = 2;
  localparam int SEC_FIRST = 6;   // first secure-only register index
  localparam int PROT_W    = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic             doWrite;
    logic             doRead;
    logic [IDX_W-1:0] idx;
  } rfStrobe_t;
endpackage

// File: rtl/apb_rf_ctrl.sv
module apb_rf_ctrl
  import apb_rf_pkg::*;
#(
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              enableIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [STRB_W-1:0] strbIn,
  input  logic [PROT_W-1:0] protIn,
  input  logic [WAIT_W-1:0] waitCfg,
  output logic              readyOut,
  output logic              errOut,
  output rfStrobe_t         strobeOut
);
  localparam int IDX_LSB = $clog2(STRB_W);
  localparam int HI_LSB  = IDX_LSB + IDX_W;

  logic [WAIT_W-1:0] waitCnt;
  logic              accessPhase;
  logic              readyInt;
  logic [IDX_W-1:0]  idx;
  logic              outRange;
  logic              secureHit;
  logic              denied;
  logic              strbOnRead;
  logic              fault;
  logic              unusedProtBits;
  logic              unusedAddrBits;

  assign accessPhase = selIn && enableIn;
  assign readyInt    = accessPhase && (waitCnt == waitCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         waitCnt <= '0;
    else if (!accessPhase || readyInt) waitCnt <= '0;
    else                               waitCnt <= waitCnt + 1'b1;
  end

  assign idx        = addrIn[HI_LSB-1:IDX_LSB];
  assign outRange   = |addrIn[ADDR_W-1:HI_LSB];
  assign secureHit  = (idx >= IDX_W'(SEC_FIRST));
  assign denied     = secureHit && protIn[1];
  assign strbOnRead = !writeIn && (|strbIn);
  assign fault      = outRange || denied || strbOnRead;

  assign unusedProtBits = protIn[0] ^ protIn[2];
  assign unusedAddrBits = ^addrIn[IDX_LSB-1:0];

  assign readyOut          = readyInt;
  assign errOut            = readyInt && fault;
  assign strobeOut.doWrite = readyInt && writeIn && !fault;
  assign strobeOut.doRead  = readyInt && !writeIn && !fault;
  assign strobeOut.idx     = idx;

  assert_ready_in_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |-> (selIn && enableIn));

  assert_err_final_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (selIn && enableIn && readyOut));

  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= waitCfg);

  assert_commit_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobeOut.doWrite && strobeOut.doRead) && !(errOut && (strobeOut.doWrite || strobeOut.doRead)));
endmodule

// File: rtl/apb_rf_dpath.sv
module apb_rf_dpath
  import apb_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobeIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic [STRB_W-1:0] strbIn,
  output logic [DATA_W-1:0] rdataOut
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0]               laneMask;

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign laneMask[b*8 +: 8] = {8{strbIn[b]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (strobeIn.doWrite) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobeIn.idx == IDX_W'(r))
          regFile[r] <= (regFile[r] & ~laneMask) | (wdataIn & laneMask);
      end
    end
  end

  assign rdataOut = strobeIn.doRead ? regFile[strobeIn.idx] : '0;

  assert_reg_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn.doWrite |=> $stable(regFile));

  assert_rdata_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn.doRead |-> (rdataOut == '0));
endmodule

// File: rtl/apb_rf_top.sv
module apb_rf_top
  import apb_rf_pkg::*;
#(
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              enableIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic [STRB_W-1:0] strbIn,
  input  logic [PROT_W-1:0] protIn,
  input  logic [WAIT_W-1:0] waitCfg,
  output logic [DATA_W-1:0] rdataOut,
  output logic              readyOut,
  output logic              errOut
);
  rfStrobe_t strobe;

  apb_rf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
    .writeIn(writeIn), .addrIn(addrIn), .strbIn(strbIn), .protIn(protIn),
    .waitCfg(waitCfg), .readyOut(readyOut), .errOut(errOut), .strobeOut(strobe)
  );

  apb_rf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobeIn(strobe), .wdataIn(wdataIn),
    .strbIn(strbIn), .rdataOut(rdataOut)
  );
endmodule

// File: tb/tb_apb_rf_top.sv
`timescale 1ns/1ps
module tb_apb_rf_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        selIn, enableIn, writeIn;
  logic [11:0] addrIn;
  logic [31:0] wdataIn;
  logic [3:0]  strbIn;
  logic [2:0]  protIn;
  logic [1:0]  waitCfg;
  logic [31:0] rdataOut;
  logic        readyOut, errOut;

  int total = 0;
  int bad = 0;
  int cycCount = 0;

  // behavioural reference state
  logic [31:0] mdl [8];
  int          waitSeen = 0;
  bit          lastDone;
  bit          lastErr;
  logic [31:0] lastRd;

  always #5 clk = ~clk;

  apb_rf_top dut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
    .writeIn(writeIn), .addrIn(addrIn), .wdataIn(wdataIn), .strbIn(strbIn),
    .protIn(protIn), .waitCfg(waitCfg), .rdataOut(rdataOut),
    .readyOut(readyOut), .errOut(errOut)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 50000) begin
      bad++;
      $display("FAIL R3: watchdog expired actual=%0d expected<=50000 cycles", cycCount);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one clock: compare outputs against the model mid-cycle, then advance the model
  task automatic stepCycle();
    bit          acc, expReady, flt, expErr;
    logic [31:0] expRd, mask;
    int          ix;
    #2;
    acc      = selIn && enableIn;
    expReady = acc && (waitSeen == int'(waitCfg));
    ix       = int'(addrIn[4:2]);
    flt      = (addrIn[11:5] != 0) || (!writeIn && strbIn != 0) || (ix >= 6 && protIn[1]);
    expErr   = expReady && flt;
    expRd    = (expReady && !writeIn && !flt) ? mdl[ix] : 32'h0;
    check(readyOut == expReady, acc ? "R3 ready" : "R2 ready outside access", 32'(readyOut), 32'(expReady));
    check(errOut == expErr, "R9 error timing", 32'(errOut), 32'(expErr));
    check(rdataOut == expRd, "R5 read data", rdataOut, expRd);
    lastDone = readyOut && acc;
    lastErr  = errOut;
    lastRd   = rdataOut;
    @(posedge clk);
    if (expReady && writeIn && !flt) begin
      mask = 32'h0;
      for (int b = 0; b < 4; b++) if (strbIn[b]) mask[b*8 +: 8] = 8'hFF;
      mdl[ix] = (mdl[ix] & ~mask) | (wdataIn & mask);
    end
    waitSeen = (acc && !expReady) ? waitSeen + 1 : 0;
    @(negedge clk);
  endtask

  task automatic idle();
    selIn = 0; enableIn = 0; strbIn = 0; writeIn = 0;
    stepCycle();
  endtask

  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p, input bit b2b,
                      output logic [31:0] rd, output bit er, output int accCycles);
    selIn = 1; enableIn = 0; writeIn = wr; addrIn = a; wdataIn = d; strbIn = s; protIn = p;
    stepCycle();
    enableIn = 1;
    accCycles = 0;
    do begin
      stepCycle();
      accCycles++;
    end while (!lastDone);
    rd = lastRd; er = lastErr;
    if (!b2b) idle();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                    input logic [2:0] p, input bit expErr, input string tag);
    logic [31:0] rd; bit er; int n;
    xfer(1'b1, a, d, s, p, 1'b0, rd, er, n);
    check(er == expErr, tag, 32'(er), 32'(expErr));
  endtask

  task automatic rdExpect(input logic [11:0] a, input logic [3:0] s, input logic [2:0] p,
                          input logic [31:0] expVal, input bit expErr, input string tag);
    logic [31:0] rd; bit er; int n;
    xfer(1'b0, a, 32'h0, s, p, 1'b0, rd, er, n);
    check(rd == expVal, tag, rd, expVal);
    check(er == expErr, tag, 32'(er), 32'(expErr));
  endtask

  initial begin
    logic [31:0] rd; bit er; int n;
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    rstN = 0; selIn = 0; enableIn = 0; writeIn = 0; addrIn = 0;
    wdataIn = 0; strbIn = 0; protIn = 0; waitCfg = 0;
    @(negedge clk);
    #2;
    check(readyOut == 0 && errOut == 0, "R1 outputs in reset", {30'h0, readyOut, errOut}, 32'h0);
    check(rdataOut == 0, "R1 rdata in reset", rdataOut, 32'h0);
    @(negedge clk);
    rstN = 1;
    idle();

    for (int i = 0; i < 8; i++) rdExpect(12'(i*4), 4'h0, 3'b000, 32'h0, 1'b0, "R1 register cleared");

    // R3: access-phase length for every wait setting
    for (int w = 0; w < 4; w++) begin
      waitCfg = 2'(w);
      xfer(1'b1, 12'h00C, 32'hA5A50000 + 32'(w), 4'hF, 3'b000, 1'b0, rd, er, n);
      check(n == w + 1, "R3 write access cycles", 32'(n), 32'(w + 1));
      xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'b000, 1'b0, rd, er, n);
      check(n == w + 1, "R3 read access cycles", 32'(n), 32'(w + 1));
      check(rd == 32'hA5A50000 + 32'(w), "R5 readback", rd, 32'hA5A50000 + 32'(w));
    end

    for (int w = 0; w < 4; w++) begin
      waitCfg = 2'(w);
      // R4: byte strobes
      wr(12'h008, 32'hFFFFFFFF, 4'hF, 3'b000, 1'b0, "R4 full write");
      wr(12'h008, 32'h12345678, 4'b0101, 3'b000, 1'b0, "R4 partial write");
      rdExpect(12'h008, 4'h0, 3'b000, 32'hFF34FF78, 1'b0, "R4 lanes 0 and 2");
      wr(12'h008, 32'h00000000, 4'h0, 3'b000, 1'b0, "R4 no-strobe write");
      rdExpect(12'h008, 4'h0, 3'b000, 32'hFF34FF78, 1'b0, "R4 no lanes updated");
      // R6: out of range aliases onto index 0
      wr(12'h000, 32'h0BADF00D, 4'hF, 3'b000, 1'b0, "R6 setup reg0");
      wr(12'h020, 32'hDEADBEEF, 4'hF, 3'b000, 1'b1, "R6 out-of-range write error");
      rdExpect(12'h000, 4'h0, 3'b000, 32'h0BADF00D, 1'b0, "R6 reg0 untouched");
      rdExpect(12'h800, 4'h0, 3'b000, 32'h0, 1'b1, "R6 out-of-range read");
      // R7: strobes on read
      rdExpect(12'h000, 4'b0010, 3'b000, 32'h0, 1'b1, "R7 read with strobe");
      // R8: secure-only registers
      wr(12'h018, 32'h5EC00006, 4'hF, 3'b000, 1'b0, "R8 secure write reg6");
      wr(12'h01C, 32'h5EC00007, 4'hF, 3'b001, 1'b0, "R8 secure write reg7");
      wr(12'h018, 32'h11111111, 4'hF, 3'b010, 1'b1, "R8 non-secure write error");
      rdExpect(12'h018, 4'h0, 3'b010, 32'h0, 1'b1, "R8 non-secure read zero");
      rdExpect(12'h018, 4'h0, 3'b000, 32'h5EC00006, 1'b0, "R8 reg6 unchanged");
      rdExpect(12'h01C, 4'h0, 3'b000, 32'h5EC00007, 1'b0, "R8 reg7 secure read");
      wr(12'h014, 32'h00005555, 4'hF, 3'b010, 1'b0, "R8 non-secure to reg5 allowed");
      rdExpect(12'h014, 4'h0, 3'b010, 32'h00005555, 1'b0, "R8 reg5 readback");
      // R10: ignored attributes and low address bits
      wr(12'h007, 32'hC0FFEE01, 4'hF, 3'b101, 1'b0, "R10 write with prot 101");
      rdExpect(12'h004, 4'h0, 3'b100, 32'hC0FFEE01, 1'b0, "R10 readback reg1");
      rdExpect(12'h006, 4'h0, 3'b001, 32'hC0FFEE01, 1'b0, "R10 low address bits");
      // R11: back-to-back transfers
      xfer(1'b1, 12'h010, 32'hB2B00010 + 32'(w), 4'hF, 3'b000, 1'b1, rd, er, n);
      xfer(1'b1, 12'h00C, 32'hB2B0000C + 32'(w), 4'hF, 3'b000, 1'b1, rd, er, n);
      xfer(1'b0, 12'h010, 32'h0, 4'h0, 3'b000, 1'b1, rd, er, n);
      check(rd == 32'hB2B00010 + 32'(w), "R11 first back-to-back", rd, 32'hB2B00010 + 32'(w));
      xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'b000, 1'b0, rd, er, n);
      check(rd == 32'hB2B0000C + 32'(w), "R11 second back-to-back", rd, 32'hB2B0000C + 32'(w));
    end

    // R2: setup-only cycles never complete
    selIn = 1; enableIn = 0; writeIn = 0; addrIn = 12'h000; strbIn = 0;
    stepCycle();
    check(!lastDone, "R2 setup does not complete", 32'(lastDone), 32'h0);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule